// File: doc/BRIEF.md
# Width-Converting Byte-Lane FIFO

This block is a single-clock FIFO whose write port and read port are each set to carry either one 9-bit byte or two bytes (18 bits) per transfer. The two widths are chosen independently. Storage is a ring of byte locations, so a two-byte word may be written once and drained as two one-byte reads, and two one-byte writes may be collected and read back as one two-byte word. An endianness selection decides which half of a two-byte word is the first byte in the byte stream. When both ports are two bytes wide, lane positions are kept exactly as written in either setting.

The width and endianness selections are static. They are taken into the block while reset is held low and are frozen from the first cycle after reset is released. Depth is counted in bytes. The full and empty flags compare the free space and the stored byte count with the number of bytes one transfer on that port moves. Read data is registered and holds its value until the next accepted read.

Top module: `bmf_fifo`

## Requirements
- R1: While and directly after reset (rst_n low at a rising edge), empty is 1, full is 0 and rd_data is 0.
- R2: With both ports two bytes wide, each read word equals the written word bit for bit, for either endianness setting.
- R3: With a two-byte write port, a one-byte read port and cfg_big_end=1, the first read of a stored word returns its bits 17..9 and the second returns its bits 8..0.
- R4: With a two-byte write port, a one-byte read port and cfg_big_end=0, the first read returns bits 8..0 and the second returns bits 17..9.
- R5: With a one-byte write port, a two-byte read port and cfg_big_end=1, the earlier of two written bytes appears in rd_data[17:9] and the later in rd_data[8:0].
- R6: With a one-byte write port, a two-byte read port and cfg_big_end=0, the earlier byte appears in rd_data[8:0] and the later in rd_data[17:9].
- R7: A one-byte port uses bits 8..0 only: wr_data[17:9] is ignored on a one-byte write port, and rd_data[17:9] is 0 on a one-byte read port.
- R8: full is 1 exactly when the free byte locations number fewer than the write width in bytes (1 or 2); with DEPTH=16 that is after 8 two-byte or 16 one-byte writes.
- R9: empty is 1 exactly when the stored bytes number fewer than the read width in bytes; a single stored byte keeps a two-byte read port empty.
- R10: A write while full and a read while empty are ignored: the stored contents, the flags and rd_data are unchanged by them.
- R11: cfg_big_end, cfg_in_wide and cfg_out_wide are sampled only while rst_n is low; changes after reset have no effect until the next reset.
- R12: An accepted read updates rd_data at the rising edge where rd_en is sampled high, and rd_data holds its value in every cycle with no accepted read.
- R13: A read and a write in the same cycle are both accepted whenever neither is blocked by its own flag, and the byte count changes by the write width minus the read width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| wr_data | input | 18 | Write data; bits 8..0 only when the write port is one byte wide |
| wr_en | input | 1 | Write request, accepted when full is 0 |
| full | output | 1 | Too little free space for one write transfer |
| rd_data | output | 18 | Registered read data |
| rd_en | input | 1 | Read request, accepted when empty is 0 |
| empty | output | 1 | Too few stored bytes for one read transfer |
| cfg_big_end | input | 1 | 1: upper half is the first byte; 0: lower half is first |
| cfg_in_wide | input | 1 | 1: write port moves two bytes; 0: one byte |
| cfg_out_wide | input | 1 | 1: read port moves two bytes; 0: one byte |

## Verification
A wrong pointer step or a wrong lane choice shows at rd_data on the very read that moves the affected byte, as a swapped half or a byte from the wrong location. A wrong byte count shows at full or empty in the cycle after the transfer that updated it. A stale or non-frozen configuration shows as a flag threshold off by one byte on the first transfer after the pins change. All eight width and endianness combinations are therefore swept through fill past full, drain past empty and an interleaved phase, and each flag and each output word is compared every cycle with a byte-stream model.

// File: rtl/bmf_pkg.sv
// Shared types for the width-converting byte-lane FIFO.
package bmf_pkg;
    // Static operating mode captured during reset.
    typedef struct packed {
        logic big_end;   // 1: upper half of a two-byte word is the first byte
        logic in_wide;   // 1: write port moves two bytes per transfer
        logic out_wide;  // 1: read port moves two bytes per transfer
    } bmf_mode_t;
endpackage

// File: rtl/bmf_mode_latch.sv
// Holds the operating mode. Samples the configuration pins on every edge
// while reset is low and freezes them from the first edge after release.
// Assumes the pins are stable during the last reset cycle.
module bmf_mode_latch
    import bmf_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  bmf_mode_t mode_in,
    output bmf_mode_t mode_q
);

    // Capture the mode only while reset is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= mode_in;
        end
    end

    // R11
    mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

endmodule

// File: rtl/bmf_ctrl.sv
// Pointer and byte-count control. Pointers address bytes; each accepted
// write advances the write pointer by the write width in bytes, each
// accepted read advances the read pointer by the read width. Flags compare
// free space and stored bytes with those widths. Assumes DEPTH is a power
// of two and at least 2, so pointers wrap by plain overflow.
module bmf_ctrl #(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          in_wide,
    input  logic          out_wide,
    output logic          full,
    output logic          empty,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr
);

    logic [CW-1:0] fill;
    logic [CW-1:0] wstep;
    logic [CW-1:0] rstep;

    // Bytes moved by one transfer on each port.
    always_comb begin
        wstep = in_wide  ? CW'(2) : CW'(1);
        rstep = out_wide ? CW'(2) : CW'(1);
    end

    // Flags and transfer acceptance.
    always_comb begin
        full  = (CW'(DEPTH) - fill) < wstep;
        empty = fill < rstep;
        wr_go = wr_en && !full;
        rd_go = rd_en && !empty;
    end

    // Advance the pointers and the byte count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_addr <= '0;
            rd_addr <= '0;
            fill    <= '0;
        end else begin
            if (wr_go) begin
                wr_addr <= wr_addr + AW'(wstep);
            end
            if (rd_go) begin
                rd_addr <= rd_addr + AW'(rstep);
            end
            fill <= fill + (wr_go ? wstep : '0) - (rd_go ? rstep : '0);
        end
    end

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R8
    never_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_go) |=> ($stable(fill) && $stable(wr_addr)));

    // R10
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && rd_en) |=> $stable(rd_addr));

    // R13
    fill_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && rd_go) |=> (fill == $past(fill) + $past(wstep) - $past(rstep)));

endmodule

// File: rtl/bmf_store.sv
// Byte-lane storage. A write puts its first byte at the write address and,
// when two bytes wide, its second byte at the next address. A read registers
// the byte at the read address in lane 0 and, when two bytes wide, the next
// byte in lane 1. Assumes the caller never reads bytes it has not written.
module bmf_store #(
    parameter int DEPTH  = 16,
    parameter int LANE_W = 9,
    localparam int AW = $clog2(DEPTH),
    localparam int NL = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              wr_wide,
    input  logic [AW-1:0]     wr_addr,
    input  logic [LANE_W-1:0] wr_first,
    input  logic [LANE_W-1:0] wr_second,
    input  logic              rd_go,
    input  logic              rd_wide,
    input  logic [AW-1:0]     rd_addr,
    output logic [LANE_W-1:0] rd_first,
    output logic [LANE_W-1:0] rd_second
);

    logic [LANE_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_next;
    logic [LANE_W-1:0] rd_lane [NL];

    // Address of the second byte of a two-byte write.
    always_comb wr_next = wr_addr + AW'(1);

    // Store one or two bytes per accepted write.
    always_ff @(posedge clk) begin
        if (wr_go) begin
            mem[wr_addr] <= wr_first;
            if (wr_wide) begin
                mem[wr_next] <= wr_second;
            end
        end
    end

    // One registered read lane per byte of a two-byte read.
    for (genvar g = 0; g < NL; g++) begin : g_rd_lane
        logic [AW-1:0] lane_addr;
        logic          lane_en;
        always_comb begin
            lane_addr = rd_addr + AW'(g);
            lane_en   = rd_go && ((g == 0) || rd_wide);
        end
        // Load this lane on an accepted read that covers it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_lane[g] <= '0;
            end else if (lane_en) begin
                rd_lane[g] <= mem[lane_addr];
            end
        end
    end

    assign rd_first  = rd_lane[0];
    assign rd_second = rd_lane[1];

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> ($stable(rd_first) && $stable(rd_second)));

endmodule

// File: rtl/bmf_fifo.sv
// Width-converting FIFO top. Maps the write bus onto the byte stream
// according to width and endianness, and maps registered read bytes back
// onto the read bus. Configuration pins are frozen at reset release.
module bmf_fifo
    import bmf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int LANE_W = 9,
    localparam int BW = 2 * LANE_W,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] wr_data,
    input  logic          wr_en,
    output logic          full,
    output logic [BW-1:0] rd_data,
    input  logic          rd_en,
    output logic          empty,
    input  logic          cfg_big_end,
    input  logic          cfg_in_wide,
    input  logic          cfg_out_wide
);

    bmf_mode_t         mode_pins;
    bmf_mode_t         mode;
    logic              wr_go;
    logic              rd_go;
    logic [AW-1:0]     wr_addr;
    logic [AW-1:0]     rd_addr;
    logic [LANE_W-1:0] wr_lo;
    logic [LANE_W-1:0] wr_hi;
    logic [LANE_W-1:0] wr_first;
    logic [LANE_W-1:0] wr_second;
    logic [LANE_W-1:0] rd_first;
    logic [LANE_W-1:0] rd_second;

    // Gather the configuration pins into one mode word.
    always_comb begin
        mode_pins.big_end  = cfg_big_end;
        mode_pins.in_wide  = cfg_in_wide;
        mode_pins.out_wide = cfg_out_wide;
    end

    bmf_mode_latch u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_in (mode_pins),
        .mode_q  (mode)
    );

    bmf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .in_wide  (mode.in_wide),
        .out_wide (mode.out_wide),
        .full     (full),
        .empty    (empty),
        .wr_go    (wr_go),
        .rd_go    (rd_go),
        .wr_addr  (wr_addr),
        .rd_addr  (rd_addr)
    );

    // Order the write halves into stream order; a one-byte write uses the low lane.
    always_comb begin
        wr_lo     = wr_data[LANE_W-1:0];
        wr_hi     = wr_data[BW-1:LANE_W];
        wr_first  = (mode.in_wide && mode.big_end) ? wr_hi : wr_lo;
        wr_second = mode.big_end ? wr_lo : wr_hi;
    end

    bmf_store #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_go     (wr_go),
        .wr_wide   (mode.in_wide),
        .wr_addr   (wr_addr),
        .wr_first  (wr_first),
        .wr_second (wr_second),
        .rd_go     (rd_go),
        .rd_wide   (mode.out_wide),
        .rd_addr   (rd_addr),
        .rd_first  (rd_first),
        .rd_second (rd_second)
    );

    // Place the stream-ordered read bytes on the output lanes.
    always_comb begin
        if (!mode.out_wide) begin
            rd_data = {{LANE_W{1'b0}}, rd_first};
        end else if (mode.big_end) begin
            rd_data = {rd_first, rd_second};
        end else begin
            rd_data = {rd_second, rd_first};
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (empty && !full && (rd_data == '0)));

    // R7
    narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode.out_wide && rd_go) |=> (rd_data[BW-1:LANE_W] == '0));

    // R12
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rd_data));

endmodule

// File: tb/bmf_fifo_tb.sv
// Sweeps all width/endianness modes against a byte-stream model.
module bmf_fifo_tb;

    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] wr_data = '0;
    logic        wr_en = 1'b0;
    logic        full;
    logic [17:0] rd_data;
    logic        rd_en = 1'b0;
    logic        empty;
    logic        cfg_big_end = 1'b0;
    logic        cfg_in_wide = 1'b0;
    logic        cfg_out_wide = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // byte-stream model
    logic [8:0]  mq [256];
    int          head, tail, mcnt;
    logic        mb, miw, mow;
    logic [17:0] last_exp;

    always #2 clk = ~clk;

    bmf_fifo #(.DEPTH(DEPTH), .LANE_W(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_en(wr_en), .full(full),
        .rd_data(rd_data), .rd_en(rd_en), .empty(empty),
        .cfg_big_end(cfg_big_end), .cfg_in_wide(cfg_in_wide), .cfg_out_wide(cfg_out_wide)
    );

    task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [17:0] pat(input int k);
        logic [8:0] a, b;
        a = 9'(k * 37 + 5);
        b = 9'(k * 91 + 300);
        return {a, b};
    endfunction

    function automatic string mode_tag();
        if (miw && mow) return "R2";
        if (miw && !mow) return mb ? "R3" : "R4";
        if (!miw && mow) return mb ? "R5" : "R6";
        return "R7";
    endfunction

    function automatic bit m_full();
        return (DEPTH - mcnt) < (miw ? 2 : 1);
    endfunction

    function automatic bit m_empty();
        return mcnt < (mow ? 2 : 1);
    endfunction

    task automatic push_byte(input logic [8:0] b);
        mq[tail] = b; tail = (tail + 1) % 256; mcnt++;
    endtask

    function automatic logic [8:0] pop_byte();
        logic [8:0] b;
        b = mq[head]; head = (head + 1) % 256; mcnt--;
        return b;
    endfunction

    // Reset with a mode, then move the pins to the opposite mode (R11 coverage).
    task automatic do_reset(input logic b, input logic iw, input logic ow);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        cfg_big_end = b; cfg_in_wide = iw; cfg_out_wide = ow;
        repeat (3) @(negedge clk);
        #1;
        chk(empty === 1'b1, "R1 empty", 18'(empty), 18'd1);
        chk(full === 1'b0, "R1 full", 18'(full), 18'd0);
        chk(rd_data === 18'd0, "R1 rd_data", rd_data, 18'd0);
        @(negedge clk);
        rst_n = 1'b1;
        mb = b; miw = iw; mow = ow;
        head = 0; tail = 0; mcnt = 0; last_exp = '0;
        cfg_big_end = ~b; cfg_in_wide = ~iw; cfg_out_wide = ~ow;
    endtask

    // One cycle: drive at negedge, check flags before the edge, data after it.
    task automatic step(input logic we, input logic [17:0] wd, input logic re);
        bit aw, ar;
        logic [8:0] b0, b1;
        string tg;
        wr_en = we; wr_data = wd; rd_en = re;
        #1;
        chk(full === m_full(), "R8 full", 18'(full), 18'(m_full()));
        chk(empty === m_empty(), "R9 empty", 18'(empty), 18'(m_empty()));
        chk(rd_data === last_exp, "R12 before edge", rd_data, last_exp);
        aw = we && !m_full();
        ar = re && !m_empty();
        @(posedge clk);
        #1;
        if (aw) begin
            if (miw) begin
                push_byte(mb ? wd[17:9] : wd[8:0]);
                push_byte(mb ? wd[8:0] : wd[17:9]);
            end else begin
                push_byte(wd[8:0]);
            end
        end
        if (ar) begin
            b0 = pop_byte();
            if (mow) begin
                b1 = pop_byte();
                last_exp = mb ? {b0, b1} : {b1, b0};
            end else begin
                last_exp = {9'd0, b0};
            end
        end
        if (ar) tg = aw ? "R13" : mode_tag();
        else if (re) tg = "R10";
        else tg = "R12";
        chk(rd_data === last_exp, tg, rd_data, last_exp);
        @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 8; c++) begin
            do_reset(c[2], c[1], c[0]);
            // fill beyond full (writes while full ignored, R10)
            for (int k = 0; k < 20; k++) step(1'b1, pat(k + 20 * c), 1'b0);
            // drain beyond empty
            for (int k = 0; k < 20; k++) step(1'b0, 18'h0, 1'b1);
            // interleaved reads and writes
            for (int k = 0; k < 40; k++) step((k % 3) != 2, pat(k + 300), (k % 2) == 0);
            for (int k = 0; k < 6; k++) step(1'b1, pat(k + 500), 1'b1);
            for (int k = 0; k < 20; k++) step(1'b0, 18'h0, 1'b1);
        end
        // R11: reset as one-byte in / two-byte out, pins then switched to two-byte in
        do_reset(1'b1, 1'b0, 1'b1);
        step(1'b1, 18'h3_0155, 1'b0);
        #1;
        chk(empty === 1'b1, "R11 one byte keeps empty", 18'(empty), 18'd1);
        chk(full === 1'b0, "R11 full", 18'(full), 18'd0);
        step(1'b1, 18'h0_00AA, 1'b0);
        step(1'b0, 18'h0, 1'b1);
        chk(rd_data === {9'h155, 9'h0AA}, "R11 latched mode data", rd_data, {9'h155, 9'h0AA});
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule